// File: doc/BRIEF.md
# Byte-Addressed Word Data Memory

A synchronous data store for a 32-bit datapath. Software sees byte addresses, but the contents are kept as an array of 32-bit words. Each word is split into four 8-bit lanes that can be written one at a time. A 2-bit operation code, qualified by an enable, picks the access: a full-word read, or a byte, halfword or full-word write. A write changes only the lanes it targets; the other lanes of the word keep their contents.

Lanes follow big-endian order. Byte offset 0 inside a word is bits 31:24, and byte offset 3 is bits 7:0. Read data is produced combinationally from the word that the address selects. Writes commit on the rising clock edge. A halfword or word access whose address is not aligned to its size writes nothing. It also raises a one-cycle error flag, so the surrounding pipeline can trap.

The depth in words is a parameter.

Top module: `byte_word_mem`

## Requirements
- R1: While `rst_ni` is low, `misalign_o` is 0 and every stored word is cleared to 0x00000000.
- R2: With `en_i`=1 and `op_i`=2'b00, `rdata_o` shows the stored word at index `addr_i[IDX_W+1:2]` in the same cycle. In every other case `rdata_o` is 0.
- R3: With `en_i`=1 and `op_i`=2'b01, `wdata_i[7:0]` is written at the rising edge into one lane at any offset. Offset 0 goes to bits 31:24, 1 to 23:16, 2 to 15:8 and 3 to 7:0. The other lanes are unchanged.
- R4: With `en_i`=1 and `op_i`=2'b10, `wdata_i[15:0]` is written into bits 31:16 for offset 0 or into bits 15:0 for offset 2. The other half of the word is unchanged.
- R5: With `en_i`=1 and `op_i`=2'b11 at offset 0, the whole `wdata_i` replaces the word. A read in any later cycle returns it.
- R6: With `en_i`=0, no operation code or address changes the stored data, and `misalign_o` is 0 in the following cycle.
- R7: A halfword write at an odd offset, or a word write at a nonzero offset, leaves the memory unchanged. It sets `misalign_o` to 1 for exactly the cycle after that clock edge.
- R8: A word read at a nonzero offset sets `misalign_o` for the following cycle. Meanwhile `rdata_o` still returns the word at index `addr_i[IDX_W+1:2]`.
- R9: Address bits above `IDX_W+1` are ignored, so addresses that differ only there refer to the same word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock; writes commit on the rising edge |
| rst_ni | input | 1 | Asynchronous active-low reset |
| en_i | input | 1 | Access enable |
| op_i | input | 2 | 00 word read, 01 byte write, 10 halfword write, 11 word write |
| addr_i | input | ADDR_W (32) | Byte address |
| wdata_i | input | DATA_W (32) | Write data, low-justified for byte and halfword writes |
| rdata_o | output | DATA_W (32) | Combinational word read data |
| misalign_o | output | 1 | One-cycle flag for a misaligned halfword or word access |

## Verification
Sequences of byte writes that walk all four offsets of one word show whether the lane order is big-endian and whether neighbouring lanes are kept. Halfword writes at offsets 0 and 2 show the same for half-word placement. Accesses at each misaligned offset, each paired with a read-back, separate a correct rejection from a write that slips through. Disabled writes and accesses that alias through the upper address bits check that the enable gates all effects and that index decoding is correct. A long pseudo-random mix of operations over a small window of words is then compared every cycle with a behavioural model.

// File: rtl/bwm_pkg.sv
package bwm_pkg;
  typedef enum logic [1:0] {
    OP_RD_WORD = 2'b00,
    OP_WR_BYTE = 2'b01,
    OP_WR_HALF = 2'b10,
    OP_WR_WORD = 2'b11
  } mem_op_e;

  localparam int LANES   = 4;
  localparam int OFF_W   = $clog2(LANES);
endpackage

// File: rtl/bwm_decode.sv
module bwm_decode
  import bwm_pkg::*;
#(
  parameter int DATA_W = 32
) (
  input  logic              en_i,
  input  mem_op_e           op_i,
  input  logic [OFF_W-1:0]  off_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic [LANES-1:0]  lane_we_o,
  output logic [DATA_W-1:0] lane_data_o,
  output logic              misalign_o,
  output logic              rd_sel_o
);
  localparam int LANE_W = DATA_W / LANES;
  localparam int HALF_W = DATA_W / 2;

  logic             aligned;
  logic [LANES-1:0] mask;

  always_comb begin
    aligned     = 1'b1;
    mask        = '0;
    lane_data_o = wdata_i;
    unique case (op_i)
      OP_RD_WORD: begin
        aligned = (off_i == '0);
      end
      OP_WR_BYTE: begin
        // big-endian: offset 0 is the top lane
        mask        = {1'b1, {(LANES-1){1'b0}}} >> off_i;
        lane_data_o = {LANES{wdata_i[LANE_W-1:0]}};
      end
      OP_WR_HALF: begin
        aligned     = ~off_i[0];
        mask        = off_i[1] ? {{(LANES/2){1'b0}}, {(LANES/2){1'b1}}}
                               : {{(LANES/2){1'b1}}, {(LANES/2){1'b0}}};
        lane_data_o = {2{wdata_i[HALF_W-1:0]}};
      end
      OP_WR_WORD: begin
        aligned = (off_i == '0);
        mask    = '1;
      end
      default: ;
    endcase
  end

  assign lane_we_o  = (en_i && aligned) ? mask : '0;
  assign misalign_o = en_i && !aligned;
  assign rd_sel_o   = en_i && (op_i == OP_RD_WORD);
endmodule

// File: rtl/bwm_array.sv
module bwm_array
  import bwm_pkg::*;
#(
  parameter int DEPTH  = 256,
  parameter int LANE_W = 8
) (
  input  logic                     clk_i,
  input  logic                     rst_ni,
  input  logic [$clog2(DEPTH)-1:0] idx_i,
  input  logic [LANES-1:0]         lane_we_i,
  input  logic [LANES*LANE_W-1:0]  lane_data_i,
  output logic [LANES*LANE_W-1:0]  rd_word_o
);
  for (genvar g = 0; g < LANES; g++) begin : g_lane
    logic [LANE_W-1:0] store [DEPTH];

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        for (int i = 0; i < DEPTH; i++) store[i] <= '0;
      end else if (lane_we_i[g]) begin
        store[idx_i] <= lane_data_i[g*LANE_W +: LANE_W];
      end
    end

    assign rd_word_o[g*LANE_W +: LANE_W] = store[idx_i];
  end
endmodule

// File: rtl/bwm_flag.sv
module bwm_flag (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic set_i,
  output logic flag_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) flag_o <= 1'b0;
    else         flag_o <= set_i;
  end
endmodule

// File: rtl/byte_word_mem.sv
module byte_word_mem
  import bwm_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int DATA_W = 32,
  parameter int DEPTH  = 256
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              en_i,
  input  logic [1:0]        op_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic [DATA_W-1:0] rdata_o,
  output logic              misalign_o
);
  localparam int IDX_W  = $clog2(DEPTH);
  localparam int LANE_W = DATA_W / LANES;

  mem_op_e           op;
  logic [IDX_W-1:0]  idx;
  logic [LANES-1:0]  lane_we;
  logic [DATA_W-1:0] lane_data;
  logic [DATA_W-1:0] rd_word;
  logic              bad_align;
  logic              rd_sel;
  logic              unused_hi_addr;

  assign op             = mem_op_e'(op_i);
  assign idx            = addr_i[IDX_W+OFF_W-1:OFF_W];
  assign unused_hi_addr = ^addr_i[ADDR_W-1:IDX_W+OFF_W];

  bwm_decode #(.DATA_W(DATA_W)) u_decode (
    .en_i       (en_i),
    .op_i       (op),
    .off_i      (addr_i[OFF_W-1:0]),
    .wdata_i    (wdata_i),
    .lane_we_o  (lane_we),
    .lane_data_o(lane_data),
    .misalign_o (bad_align),
    .rd_sel_o   (rd_sel)
  );

  bwm_array #(.DEPTH(DEPTH), .LANE_W(LANE_W)) u_array (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .idx_i      (idx),
    .lane_we_i  (lane_we),
    .lane_data_i(lane_data),
    .rd_word_o  (rd_word)
  );

  bwm_flag u_flag (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .set_i (bad_align),
    .flag_o(misalign_o)
  );

  assign rdata_o = rd_sel ? rd_word : '0;

  // R7: misaligned writes must not reach any lane
  assert_no_misaligned_write_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (en_i && ((op_i == 2'b10 && addr_i[0]) || (op_i == 2'b11 && addr_i[1:0] != 2'b00)))
      |-> (lane_we == '0));

  // R3: a byte write touches exactly one lane
  assert_byte_one_lane_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (en_i && op_i == 2'b01) |-> ($countones(lane_we) == 1));

  // R7, R8: misalignment raises the flag on the following cycle
  assert_flag_follows_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (en_i && ((op_i == 2'b10 && addr_i[0]) ||
              (op_i != 2'b01 && op_i != 2'b10 && addr_i[1:0] != 2'b00)))
      |=> misalign_o);

  // R6: disabled cycle writes nothing and clears the flag next cycle
  assert_idle_quiet_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !en_i |-> (lane_we == '0) ##1 !misalign_o);

  // R2: read data is zero unless a word read is enabled
  assert_rdata_gated_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(en_i && op_i == 2'b00) |-> (rdata_o == '0));
endmodule

// File: tb/byte_word_mem_test.sv
module byte_word_mem_test;
  localparam int DEPTH = 256;
  localparam time HALF = 10ns;

  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        en_i = 1'b0;
  logic [1:0]  op_i = 2'b00;
  logic [31:0] addr_i = '0;
  logic [31:0] wdata_i = '0;
  logic [31:0] rdata_o;
  logic        misalign_o;

  int errors = 0;
  int checks = 0;
  logic [31:0] model [DEPTH];
  logic [31:0] seed = 32'h1234_5678;

  always #HALF clk_i = ~clk_i;

  byte_word_mem uut (
    .clk_i(clk_i), .rst_ni(rst_ni), .en_i(en_i), .op_i(op_i),
    .addr_i(addr_i), .wdata_i(wdata_i), .rdata_o(rdata_o), .misalign_o(misalign_o)
  );

  task automatic check(string req, string what, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  function automatic logic [31:0] next_rand();
    seed ^= seed << 13;
    seed ^= seed >> 17;
    seed ^= seed << 5;
    return seed;
  endfunction

  // one access: drive at negedge, check read, clock, check flag
  task automatic step(string req, logic en, logic [1:0] op, logic [31:0] addr, logic [31:0] wd);
    logic [31:0] exp_rd;
    logic        exp_err;
    int          ix;
    int          off;
    @(negedge clk_i);
    en_i = en; op_i = op; addr_i = addr; wdata_i = wd;
    ix  = int'(addr[9:2]);
    off = int'(addr[1:0]);
    exp_rd  = (en && op == 2'b00) ? model[ix] : 32'h0;
    exp_err = en && ((op == 2'b10 && off % 2 != 0) ||
                     ((op == 2'b00 || op == 2'b11) && off != 0));
    #2;
    check(req, "rdata", rdata_o, exp_rd);
    @(posedge clk_i);
    if (en && !exp_err) begin
      case (op)
        2'b01: model[ix][31 - 8*off -: 8] = wd[7:0];
        2'b10: model[ix][31 - 8*off -: 16] = wd[15:0];
        2'b11: model[ix] = wd;
        default: ;
      endcase
    end
    #2;
    check(req, "misalign", {31'b0, misalign_o}, {31'b0, exp_err});
  endtask

  task automatic rd(string req, int word, logic [31:0] hi = 0);
    step(req, 1'b1, 2'b00, (hi << 10) | (word << 2), 32'h0);
  endtask

  initial begin
    #(HALF * 2 * 200000);
    errors++;
    $display("FAIL watchdog: actual=running expected=finished");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    for (int i = 0; i < DEPTH; i++) model[i] = '0;
    #(HALF * 5);
    check("R1", "misalign in reset", {31'b0, misalign_o}, 32'h0);
    @(negedge clk_i);
    rst_ni = 1'b1;

    // R1: all words cleared
    for (int i = 0; i < DEPTH; i++) rd("R1", i);

    // R5: full word writes and readback
    step("R5", 1, 2'b11, 32'h0000_0010, 32'hDEAD_BEEF);
    step("R5", 1, 2'b11, 32'h0000_0014, 32'h0123_4567);
    step("R5", 1, 2'b11, 32'h0000_03FC, 32'hA5A5_5A5A);
    rd("R5", 4); rd("R5", 5); rd("R5", 255);

    // R3: byte walk over word 8, big-endian lanes
    for (int k = 0; k < 4; k++) begin
      step("R3", 1, 2'b01, 32'h20 + k, 32'hFFFF_FF10 + k);
      rd("R3", 8);
    end
    step("R3", 1, 2'b01, 32'h0000_0012, 32'h0000_0077);
    rd("R3", 4);

    // R4: halfwords at both aligned offsets
    step("R4", 1, 2'b10, 32'h0000_0014, 32'hFFFF_CAFE);
    rd("R4", 5);
    step("R4", 1, 2'b10, 32'h0000_0016, 32'h0000_F00D);
    rd("R4", 5);

    // R6: disabled accesses change nothing
    step("R6", 0, 2'b11, 32'h0000_0010, 32'h1111_1111);
    step("R6", 0, 2'b01, 32'h0000_0021, 32'h2222_2222);
    step("R6", 0, 2'b11, 32'h0000_0013, 32'h3333_3333);
    step("R6", 0, 2'b00, 32'h0000_0010, 32'h0);
    rd("R6", 4); rd("R6", 8);

    // R7: misaligned writes rejected
    step("R7", 1, 2'b10, 32'h0000_0011, 32'h0000_9999);
    step("R7", 1, 2'b10, 32'h0000_0013, 32'h0000_9999);
    step("R7", 1, 2'b11, 32'h0000_0011, 32'h9999_9999);
    step("R7", 1, 2'b11, 32'h0000_0012, 32'h9999_9999);
    step("R7", 1, 2'b11, 32'h0000_0013, 32'h9999_9999);
    rd("R7", 4);

    // R8: misaligned reads flag but return the word
    step("R8", 1, 2'b00, 32'h0000_0015, 32'h0);
    step("R8", 1, 2'b00, 32'h0000_0023, 32'h0);
    rd("R8", 5);

    // R9: upper address bits alias
    step("R9", 1, 2'b11, 32'hFFFF_FC24, 32'hBADC_0FFE);
    rd("R9", 9, 32'h0012_3456);
    rd("R9", 9);
    step("R9", 1, 2'b01, 32'h8000_0027, 32'h0000_0042);
    rd("R9", 9, 32'h0000_0001);

    // R2: random mix over a small window
    for (int n = 0; n < 3000; n++) begin
      logic [31:0] r;
      logic [31:0] a;
      r = next_rand();
      a = {r[31:10], 5'b0, r[4:2], r[1:0]};
      step("R2", r[9:8] != 2'b00, r[6:5], a, next_rand());
    end
    for (int i = 0; i < 8; i++) rd("R2", i);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule